// File: doc/BRIEF.md
# Six-Stage Pipeline Occupancy Controller

This block keeps track of which instruction occupies each of six in-order pipeline stages: fetch, decode, operand-address calculation, operand fetch, execute and write-back. Every cycle it can take one new instruction into fetch. The environment supplies each instruction's tag together with a conditional-branch flag, the branch outcome and the target tag. The block numbers instructions sequentially from its own fetch pointer, and it shows the tag it is about to fetch on `fetch_tag` so that the environment can present that instruction's branch information in the same cycle.

Branches are resolved in the execute stage. A taken branch that leaves execute invalidates every younger instruction that is still in flight. On that same edge, fetch is redirected to the target tag. The result is a gap of four cycles in which nothing completes. Fetch then carries on sequentially from the target.

The outputs are a per-stage valid vector and tag vector, a completion strobe with its tag, and a free-running cycle counter. A stall input freezes the whole pipe.

Top module: `pipe_occupancy_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every stage valid bit and sets `cycle_count` to 0. After reset the first tag fetched is 1, so `fetch_tag` reads 1.
- R2: Stage s (0 = fetch … 5 = write-back) is reported in `stage_vld[s]` and in `stage_tag[s*TAG_W +: TAG_W]`. On every edge without stall, an entry moves exactly one stage. `done_vld`/`done_tag` show the write-back stage. With continuous issue from reset, tag i completes at `cycle_count` = i+5.
- R3: Nine straight-line instructions issued from reset have all completed by `cycle_count` = 14.
- R4: When a valid taken branch is in stage 4 on an edge without stall, stages 1 to 4 are invalid after that edge. The instructions that were in stages 0 to 3 never complete.
- R5: On that same edge, fetch loads the branch target (if `issue_en` is high) and then continues with target+1, target+2 and so on. A branch at tag 3 to tag 15 leaves `cycle_count` 9 to 12 without a completion, and tag 15 completes at 13.
- R6: A branch whose taken bit is 0 causes no flush and no bubble. Later tags complete one per cycle at i+5.
- R7: While `stall` is high, `stage_vld`, `stage_tag`, `done_vld` and `done_tag` hold their values and no tag is consumed.
- R8: `cycle_count` increments by one on every edge outside reset, stalled edges included, and wraps modulo 2^CYC_W.
- R9: With `issue_en` low on an edge without stall, stage 0 becomes invalid and the fetch pointer is not advanced, so the same tag is fetched later.
- R10: The branch flag, outcome and target sampled with a fetched tag travel with it. A taken branch held in execute by a stall redirects only on the first edge without stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze all stages and fetch |
| issue_en | input | 1 | Take the instruction at `fetch_tag` into fetch this edge |
| br_flag | input | 1 | Instruction at `fetch_tag` is a conditional branch |
| br_taken | input | 1 | Outcome of that branch |
| br_target | input | TAG_W | Target tag of that branch |
| fetch_tag | output | TAG_W | Tag fetched on the coming edge |
| stage_vld | output | 6 | Per-stage occupancy |
| stage_tag | output | 6*TAG_W | Per-stage tags, stage 0 in the low bits |
| done_vld | output | 1 | An instruction is in write-back this cycle |
| done_tag | output | TAG_W | Tag of that instruction |
| cycle_count | output | CYC_W | Cycles since reset |

## Verification
The hardest situation to reach is a taken branch that sits in execute while the pipe is stalled, and that then redirects into a stream that contains an issue bubble and a second taken branch. To get there, the stimulus drives the branch information from the bench's own prediction of the fetched tag. It raises the stall exactly on the cycle the first branch reaches execute, then drops `issue_en` for one cycle before the second branch resolves. A behavioural queue model runs alongside and is compared on every cycle. Completion times are also checked against the absolute cycle numbers that follow from the stated timing.

// File: rtl/pocc_pkg.sv
package pocc_pkg;
  localparam int NUM_ST = 6;
  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_OPND, ST_EXEC, ST_WRITE
  } stage_e;
  localparam int EX_IDX = int'(ST_EXEC);
  localparam int WB_IDX = int'(ST_WRITE);
endpackage

// File: rtl/pocc_fetch.sv
module pocc_fetch #(
  parameter int TAG_W     = 8,
  parameter int START_TAG = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             issue_en,
  input  logic             redirect,
  input  logic [TAG_W-1:0] redirect_tag,
  output logic [TAG_W-1:0] fetch_tag,
  output logic             fetch_go
);
  logic [TAG_W-1:0] next_q;

  assign fetch_tag = redirect ? redirect_tag : next_q;
  assign fetch_go  = issue_en & ~stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_q <= TAG_W'(START_TAG);
    end else if (!stall) begin
      if (fetch_go)      next_q <= fetch_tag + 1'b1;
      else if (redirect) next_q <= redirect_tag;
    end
  end
endmodule

// File: rtl/pocc_stage_array.sv
module pocc_stage_array
  import pocc_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stall,
  input  logic                    fetch_go,
  input  logic [TAG_W-1:0]        fetch_tag,
  input  logic                    in_br,
  input  logic                    in_tk,
  input  logic [TAG_W-1:0]        in_tgt,
  output logic [NUM_ST-1:0]       vld,
  output logic [NUM_ST*TAG_W-1:0] tags,
  output logic                    redirect,
  output logic [TAG_W-1:0]        redirect_tag
);
  logic [NUM_ST-1:0] vld_q;
  logic [TAG_W-1:0]  tag_q [NUM_ST];
  logic              br_q  [EX_IDX+1];
  logic              tk_q  [EX_IDX+1];
  logic [TAG_W-1:0]  tgt_q [EX_IDX+1];

  // resolution point: a valid taken branch leaving execute
  assign redirect     = ~stall & vld_q[EX_IDX] & br_q[EX_IDX] & tk_q[EX_IDX];
  assign redirect_tag = tgt_q[EX_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (!stall) begin
      vld_q[0] <= fetch_go;
      for (int s = 1; s < NUM_ST; s++)
        vld_q[s] <= vld_q[s-1] & ~(redirect & (s <= EX_IDX));
    end
  end

  always_ff @(posedge clk) begin
    if (!stall) begin
      tag_q[0] <= fetch_tag;
      br_q[0]  <= in_br;
      tk_q[0]  <= in_tk;
      tgt_q[0] <= in_tgt;
      for (int s = 1; s <= EX_IDX; s++) begin
        tag_q[s] <= tag_q[s-1];
        br_q[s]  <= br_q[s-1];
        tk_q[s]  <= tk_q[s-1];
        tgt_q[s] <= tgt_q[s-1];
      end
      tag_q[WB_IDX] <= tag_q[WB_IDX-1];
    end
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_out
    assign vld[g] = vld_q[g];
    assign tags[g*TAG_W +: TAG_W] = tag_q[g];
  end
endmodule

// File: rtl/pocc_cycle_ctr.sv
module pocc_cycle_ctr #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CYC_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/pipe_occupancy_ctrl.sv
module pipe_occupancy_ctrl
  import pocc_pkg::*;
#(
  parameter int TAG_W     = 8,
  parameter int CYC_W     = 16,
  parameter int START_TAG = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stall,
  input  logic                    issue_en,
  input  logic                    br_flag,
  input  logic                    br_taken,
  input  logic [TAG_W-1:0]        br_target,
  output logic [TAG_W-1:0]        fetch_tag,
  output logic [NUM_ST-1:0]       stage_vld,
  output logic [NUM_ST*TAG_W-1:0] stage_tag,
  output logic                    done_vld,
  output logic [TAG_W-1:0]        done_tag,
  output logic [CYC_W-1:0]        cycle_count
);
  logic             redirect;
  logic [TAG_W-1:0] redirect_tag;
  logic             fetch_go;

  pocc_fetch #(.TAG_W(TAG_W), .START_TAG(START_TAG)) u_fetch (
    .clk(clk), .rst(rst), .stall(stall), .issue_en(issue_en),
    .redirect(redirect), .redirect_tag(redirect_tag),
    .fetch_tag(fetch_tag), .fetch_go(fetch_go)
  );

  pocc_stage_array #(.TAG_W(TAG_W)) u_stages (
    .clk(clk), .rst(rst), .stall(stall), .fetch_go(fetch_go),
    .fetch_tag(fetch_tag), .in_br(br_flag), .in_tk(br_taken),
    .in_tgt(br_target), .vld(stage_vld), .tags(stage_tag),
    .redirect(redirect), .redirect_tag(redirect_tag)
  );

  pocc_cycle_ctr #(.CYC_W(CYC_W)) u_cyc (
    .clk(clk), .rst(rst), .count(cycle_count)
  );

  assign done_vld = stage_vld[WB_IDX];
  assign done_tag = stage_tag[WB_IDX*TAG_W +: TAG_W];
endmodule

// File: rtl/pipe_occupancy_ctrl_chk.sv
module pipe_occupancy_ctrl_chk #(
  parameter int TAG_W = 8,
  parameter int CYC_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               stall,
  input logic               issue_en,
  input logic               redirect,
  input logic [TAG_W-1:0]   fetch_tag,
  input logic [5:0]         stage_vld,
  input logic [6*TAG_W-1:0] stage_tag,
  input logic               done_vld,
  input logic [TAG_W-1:0]   done_tag,
  input logic [CYC_W-1:0]   cycle_count
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (stage_vld == '0 && cycle_count == '0));

  a_r2_wb_follows_ex: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (done_vld == $past(stage_vld[4]) &&
                (!done_vld || done_tag == $past(stage_tag[4*TAG_W +: TAG_W]))));

  a_r4_flush_younger: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (stage_vld[4:1] == 4'b0000));

  a_r5_fetch_loads_tag: assert property (@(posedge clk) disable iff (rst)
    (issue_en && !stall) |=> (stage_vld[0] && stage_tag[TAG_W-1:0] == $past(fetch_tag)));

  a_r7_stall_freezes: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(stage_vld) && $stable(stage_tag) && $stable(done_vld)));

  a_r8_cycle_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cycle_count == CYC_W'($past(cycle_count) + 1'b1));

  a_r9_bubble: assert property (@(posedge clk) disable iff (rst)
    (!issue_en && !stall) |=> !stage_vld[0]);

  a_r10_no_redirect_in_stall: assert property (@(posedge clk) disable iff (rst)
    stall |-> !redirect);
endmodule

bind pipe_occupancy_ctrl pipe_occupancy_ctrl_chk #(.TAG_W(TAG_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .issue_en(issue_en), .redirect(redirect),
  .fetch_tag(fetch_tag), .stage_vld(stage_vld), .stage_tag(stage_tag),
  .done_vld(done_vld), .done_tag(done_tag), .cycle_count(cycle_count)
);

// File: tb/pipe_occupancy_ctrl_tb.sv
module pipe_occupancy_ctrl_tb;
  localparam int TW = 8;
  localparam int CW = 16;

  logic clk = 0;
  logic rst = 1, stall = 0, issue_en = 0, br_flag = 0, br_taken = 0;
  logic [TW-1:0] br_target = '0;
  logic [TW-1:0] fetch_tag;
  logic [5:0] stage_vld;
  logic [6*TW-1:0] stage_tag;
  logic done_vld;
  logic [TW-1:0] done_tag;
  logic [CW-1:0] cycle_count;

  pipe_occupancy_ctrl #(.TAG_W(TW), .CYC_W(CW)) u_dut (
    .clk(clk), .rst(rst), .stall(stall), .issue_en(issue_en),
    .br_flag(br_flag), .br_taken(br_taken), .br_target(br_target),
    .fetch_tag(fetch_tag), .stage_vld(stage_vld), .stage_tag(stage_tag),
    .done_vld(done_vld), .done_tag(done_tag), .cycle_count(cycle_count)
  );

  always #4 clk = ~clk;

  typedef struct { int tag; int st; bit br; bit tk; int tgt; } rec_t;
  rec_t q[$];
  int mnext, mcyc, sc;
  int checks = 0, fails = 0;
  bit finished = 0;
  int done_at[int];
  bit cyc_done[int];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic void prog(input int t, output bit b, output bit k, output int g);
    b = 0; k = 0; g = 0;
    case (sc)
      2: if (t == 3) begin b = 1; k = 1; g = 15; end
      3: if (t == 3) begin b = 1; k = 0; g = 15; end
      4: begin
        if (t == 2)  begin b = 1; k = 1; g = 40; end
        if (t == 40) begin b = 1; k = 1; g = 60; end
      end
      default: ;
    endcase
  endfunction

  task automatic compare();
    bit [5:0] ev = '0;
    int et[6];
    for (int s = 0; s < 6; s++) et[s] = 0;
    foreach (q[i]) begin ev[q[i].st] = 1; et[q[i].st] = q[i].tag & 255; end
    chk(stage_vld == ev, "R2 occupancy vs model", int'(stage_vld), int'(ev));
    for (int s = 0; s < 6; s++)
      if (ev[s]) chk(int'(stage_tag[s*TW +: TW]) == et[s], "R2 stage tag vs model",
                     int'(stage_tag[s*TW +: TW]), et[s]);
    chk(done_vld == ev[5], "R2 completion strobe", int'(done_vld), int'(ev[5]));
    chk(int'(cycle_count) == (mcyc & 16'hffff), "R8 cycle count", int'(cycle_count), mcyc);
    if (done_vld) begin
      done_at[int'(done_tag)] = int'(cycle_count);
      cyc_done[int'(cycle_count)] = 1;
    end
  endtask

  task automatic step(input bit s, input bit en);
    bit redir = 0, b, k;
    int rtgt = 0, ftag, g;
    compare();
    foreach (q[i]) if (q[i].st == 4 && q[i].br && q[i].tk) begin redir = !s; rtgt = q[i].tgt; end
    ftag = redir ? rtgt : mnext;
    prog(ftag, b, k, g);
    stall = s; issue_en = en; br_flag = b; br_taken = k; br_target = TW'(g);
    @(posedge clk);
    if (!s) begin
      if (redir) for (int i = q.size() - 1; i >= 0; i--) if (q[i].st < 4) q.delete(i);
      foreach (q[i]) q[i].st++;
      for (int i = q.size() - 1; i >= 0; i--) if (q[i].st > 5) q.delete(i);
      if (en) begin
        rec_t r; r.tag = ftag; r.st = 0; r.br = b; r.tk = k; r.tgt = g;
        q.push_back(r); mnext = ftag + 1;
      end else if (redir) mnext = rtgt;
    end
    mcyc++;
    @(negedge clk);
  endtask

  task automatic do_reset(input int scen);
    @(negedge clk);
    rst = 1; stall = 0; issue_en = 0; br_flag = 0; br_taken = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    q.delete(); mnext = 1; mcyc = 0; sc = scen;
    done_at.delete(); cyc_done.delete();
  endtask

  function automatic int dat(input int t);
    return done_at.exists(t) ? done_at[t] : -1;
  endfunction

  initial begin
    // scenario 1: straight line
    do_reset(1);
    chk(stage_vld == 6'b0, "R1 valid cleared", int'(stage_vld), 0);
    chk(cycle_count == 0, "R1 cycle zero", int'(cycle_count), 0);
    chk(fetch_tag == 1, "R1 first fetch tag", int'(fetch_tag), 1);
    repeat (9) step(0, 1);
    repeat (8) step(0, 0);
    for (int i = 1; i <= 9; i++) chk(dat(i) == i + 5, "R2 completion time", dat(i), i + 5);
    chk(dat(9) == 14, "R3 nine done by 14 (54 unpipelined)", dat(9), 14);

    // scenario 2: taken branch 3 -> 15
    do_reset(2);
    repeat (20) step(0, 1);
    for (int c = 9; c <= 12; c++) chk(!cyc_done.exists(c), "R5 gap without completion", c, 0);
    for (int t = 4; t <= 7; t++) chk(dat(t) == -1, "R4 flushed tag never completes", dat(t), -1);
    chk(dat(3) == 8, "R4 branch itself completes", dat(3), 8);
    chk(dat(15) == 13, "R5 target completes", dat(15), 13);
    chk(dat(16) == 14, "R5 sequential after target", dat(16), 14);

    // scenario 3: not-taken branch with an issue bubble
    do_reset(3);
    repeat (4) step(0, 1);
    step(0, 0);
    chk(fetch_tag == 5, "R9 bubble keeps fetch pointer", int'(fetch_tag), 5);
    step(0, 0);
    repeat (10) step(0, 1);
    for (int i = 1; i <= 4; i++) chk(dat(i) == i + 5, "R6 not-taken no bubble", dat(i), i + 5);
    chk(dat(5) == 12, "R9 tag reused after bubble", dat(5), 12);
    chk(dat(15) == -1, "R6 target never fetched", dat(15), -1);

    // scenario 4: stall with taken branch in execute, then chained branch
    do_reset(4);
    repeat (6) step(0, 1);
    repeat (3) step(1, 1);
    chk(stage_vld == 6'h3f, "R7 stall keeps occupancy", int'(stage_vld), 63);
    chk(int'(stage_tag[4*TW +: TW]) == 2, "R10 branch held in execute", int'(stage_tag[4*TW +: TW]), 2);
    chk(cycle_count == 9, "R8 counts through stall", int'(cycle_count), 9);
    repeat (2) step(0, 1);
    step(0, 0);
    repeat (10) step(0, 1);
    chk(dat(2) == 10, "R10 branch completes after stall", dat(2), 10);
    for (int t = 3; t <= 6; t++) chk(dat(t) == -1, "R10 deferred flush", dat(t), -1);
    chk(dat(40) == 15, "R5 first target", dat(40), 15);
    for (int t = 41; t <= 43; t++) chk(dat(t) == -1, "R4 second flush", dat(t), -1);
    chk(dat(60) == 20, "R5 chained target", dat(60), 20);
    compare();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule